// File: doc/BRIEF.md
# CAN Board Host Glue

This block sits between a simple host register port and a byte-wide CAN controller core. It decodes three separate host windows, each with its own select input. The bridge window holds one 32-bit interrupt control and status word. The controller window forwards byte reads and writes to the core, but only for its lowest 32 offsets. The identification window returns a fixed version byte.

The core's interrupt line reaches the host only through an enable bit in the control word, and the host output is registered. A read of the control word also shows the live level of the core's interrupt. When software flips the enable bit while the core interrupt is pending, the host line takes the new enable value on the next clock edge. Every read returns its data one clock after the strobe. The shared read bus carries zero in any cycle that does not follow a read.

Top module: `can_host_glue`

## Requirements
- R1: In the bridge window only offset 0x38 is implemented. A read at any other bridge offset returns 0, and a write there changes nothing that a later read of 0x38 or the host interrupt shows.
- R2: A write to bridge offset 0x38 stores all 32 data bits. A later read returns those bits unchanged, except bit 23.
- R3: On a read of bridge offset 0x38, bit 23 holds the core interrupt level sampled in the read cycle, whatever was written to that bit.
- R4: Bit 13 of the control word is the interrupt enable. After each clock edge, host_irq equals core_irq in the previous cycle ANDed with the enable as stored by that edge. Core interrupt edges therefore pass while the enable is set and are held off while it is clear. Toggling the enable while core_irq is high drives host_irq to the new enable value.
- R5: Read data appears on rdata in the cycle after the read strobe. In every cycle that does not follow a read, rdata is 0.
- R6: A controller-window access at an offset below 0x20 raises core_rd or core_wr in the same cycle. It puts offset bits [4:0] on core_addr and wdata[7:0] on core_wdata. A read returns core_rdata, zero-extended to 32 bits.
- R7: A controller-window access at offset 0x20 or above raises neither core strobe, and a read there returns 0.
- R8: In the identification window, a read of offset 7 returns 0xD0 (version 13 in bits [7:4], zero in bits [3:0]). Reads of other offsets return 0, and writes have no effect.
- R9: A synchronous active-high reset clears the control word, so host_irq goes to 0 and the interrupt is disabled. core_rst is high after every clock edge that samples rst high and low after the first edge that samples it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bridge_sel | input | 1 | Selects the bridge window |
| ctrl_sel | input | 1 | Selects the controller window |
| ident_sel | input | 1 | Selects the identification window |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 7 | Byte offset within the selected window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid one clock after rd_en |
| core_rst | output | 1 | Reset to the controller core |
| core_rd | output | 1 | Read strobe to the core |
| core_wr | output | 1 | Write strobe to the core |
| core_addr | output | 5 | Core register offset |
| core_wdata | output | 8 | Core write byte |
| core_rdata | input | 8 | Core read byte, valid in the strobe cycle |
| core_irq | input | 1 | Raw core interrupt level, synchronous to clk |
| host_irq | output | 1 | Gated, registered host interrupt |

## Verification
The interrupt path is driven with core edges while the enable is set and again while it is clear. Enable toggles are applied both with the core interrupt pending and idle. This separates a gate that follows edges from one that holds, and shows whether a toggle re-drives the pin at once. The control word is written with bit 23 set and read back with the core interrupt low and high, so a stored status bit cannot pass for the live one. Controller offsets 0x05, 0x1F, 0x20 and 0x7F probe both sides of the 32-byte limit. Identification reads at offsets 7 and 0, plus a write to offset 7, show that only the version byte is visible.

// File: rtl/can_glue_pkg.sv
package can_glue_pkg;
    localparam int            HOST_AW      = 7;
    localparam int            HOST_DW      = 32;
    localparam int            CORE_AW      = 5;
    localparam int            CORE_DW      = 8;
    localparam logic [6:0]    CSR_OFS      = 7'h38;
    localparam int            CSR_EN_BIT   = 13;
    localparam int            CSR_STAT_BIT = 23;
    localparam logic [6:0]    ID_OFS       = 7'h07;
    localparam int            ID_VERSION   = 13;
endpackage

// File: rtl/cg_bridge_csr.sv
module cg_bridge_csr
    import can_glue_pkg::*;
#(
    parameter int              AW       = HOST_AW,
    parameter int              DW       = HOST_DW,
    parameter logic [AW-1:0]   OFS      = CSR_OFS,
    parameter int              EN_BIT   = CSR_EN_BIT,
    parameter int              STAT_BIT = CSR_STAT_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          rd,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          core_irq,
    output logic [DW-1:0] rdata,
    output logic          host_irq
);
    typedef struct packed {
        logic [DW-1:0] csr;
        logic          lvl;
        logic          pin;
        logic [DW-1:0] rdata;
    } st_t;

    st_t  s_d, s_q;
    logic hit_rd, hit_wr, en_now, en_next;

    always_comb begin
        s_d       = s_q;
        s_d.rdata = '0;
        s_d.lvl   = core_irq;
        hit_rd    = sel && rd && (addr == OFS);
        hit_wr    = sel && wr && (addr == OFS);
        en_now    = s_q.csr[EN_BIT];
        en_next   = hit_wr ? wdata[EN_BIT] : en_now;
        if (hit_rd) begin
            s_d.rdata           = s_q.csr;
            s_d.rdata[STAT_BIT] = core_irq;
        end
        if (hit_wr) s_d.csr = wdata;
        if (hit_wr && core_irq && (en_next != en_now))
            s_d.pin = en_next;
        else if ((core_irq != s_q.lvl) && en_now)
            s_d.pin = core_irq;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rdata    = s_q.rdata;
    assign host_irq = s_q.pin;

    a_r4_pin_tracks_gate: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (host_irq == ($past(core_irq) & s_q.csr[EN_BIT])));
    a_r3_live_status: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(hit_rd)) |-> (rdata[STAT_BIT] == $past(core_irq)));
    a_r1_other_offset_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel && rd && (addr != OFS))) |-> (rdata == '0));
    a_r2_word_held: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit_wr)) |-> $stable(s_q.csr));
endmodule

// File: rtl/cg_ctrl_pass.sv
module cg_ctrl_pass
    import can_glue_pkg::*;
#(
    parameter int AW  = HOST_AW,
    parameter int DW  = HOST_DW,
    parameter int CAW = CORE_AW,
    parameter int CDW = CORE_DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           sel,
    input  logic           rd,
    input  logic           wr,
    input  logic [AW-1:0]  addr,
    input  logic [CDW-1:0] wbyte,
    input  logic [CDW-1:0] core_rdata,
    output logic           core_rd,
    output logic           core_wr,
    output logic [CAW-1:0] core_addr,
    output logic [CDW-1:0] core_wdata,
    output logic [DW-1:0]  rdata
);
    typedef struct packed {
        logic [DW-1:0] rdata;
    } st_t;

    st_t  s_d, s_q;
    logic in_range;

    always_comb begin
        in_range   = (addr[AW-1:CAW] == '0);
        core_rd    = sel && rd && in_range;
        core_wr    = sel && wr && in_range;
        core_addr  = addr[CAW-1:0];
        core_wdata = wbyte;
        s_d.rdata  = '0;
        if (core_rd) s_d.rdata[CDW-1:0] = core_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rdata = s_q.rdata;

    a_r6_byte_returned: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(core_rd)) |-> (rdata == DW'($past(core_rdata))));
    a_r7_high_offset_zero: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel && rd && !in_range)) |-> (rdata == '0));
endmodule

// File: rtl/cg_ident_rom.sv
module cg_ident_rom
    import can_glue_pkg::*;
#(
    parameter int            AW      = HOST_AW,
    parameter int            DW      = HOST_DW,
    parameter logic [AW-1:0] OFS     = ID_OFS,
    parameter int            VERSION = ID_VERSION
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata
);
    localparam logic [7:0] ID_BYTE = {4'(VERSION), 4'h0};

    typedef struct packed {
        logic [DW-1:0] rdata;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d.rdata = '0;
        if (sel && rd && (addr == OFS)) s_d.rdata = DW'(ID_BYTE);
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign rdata = s_q.rdata;

    a_r8_version_byte: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sel && rd && (addr == OFS))) |-> (rdata == DW'(8'hD0)));
endmodule

// File: rtl/can_host_glue.sv
module can_host_glue
    import can_glue_pkg::*;
#(
    parameter int AW  = HOST_AW,
    parameter int DW  = HOST_DW,
    parameter int CAW = CORE_AW,
    parameter int CDW = CORE_DW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bridge_sel,
    input  logic           ctrl_sel,
    input  logic           ident_sel,
    input  logic           rd_en,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           core_rst,
    output logic           core_rd,
    output logic           core_wr,
    output logic [CAW-1:0] core_addr,
    output logic [CDW-1:0] core_wdata,
    input  logic [CDW-1:0] core_rdata,
    input  logic           core_irq,
    output logic           host_irq
);
    typedef struct packed {
        logic core_rst;
    } st_t;

    st_t           s_d, s_q;
    logic [DW-1:0] rd_bridge, rd_ctrl, rd_ident;

    cg_bridge_csr #(.AW(AW), .DW(DW)) u_bridge (
        .clk(clk), .rst(rst), .sel(bridge_sel), .rd(rd_en), .wr(wr_en),
        .addr(addr), .wdata(wdata), .core_irq(core_irq),
        .rdata(rd_bridge), .host_irq(host_irq)
    );

    cg_ctrl_pass #(.AW(AW), .DW(DW), .CAW(CAW), .CDW(CDW)) u_ctrl (
        .clk(clk), .rst(rst), .sel(ctrl_sel), .rd(rd_en), .wr(wr_en),
        .addr(addr), .wbyte(wdata[CDW-1:0]), .core_rdata(core_rdata),
        .core_rd(core_rd), .core_wr(core_wr), .core_addr(core_addr),
        .core_wdata(core_wdata), .rdata(rd_ctrl)
    );

    cg_ident_rom #(.AW(AW), .DW(DW)) u_ident (
        .clk(clk), .rst(rst), .sel(ident_sel), .rd(rd_en), .addr(addr),
        .rdata(rd_ident)
    );

    always_comb begin
        s_d.core_rst = rst;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign core_rst = s_q.core_rst;
    assign rdata    = rd_bridge | rd_ctrl | rd_ident;

    a_r5_read_latency: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (rdata != '0)) |-> $past(rd_en));
endmodule

// File: tb/sim_can_host_glue.sv
`timescale 1ns/1ps
module sim_can_host_glue;
    logic        clk = 1'b0;
    logic        rst;
    logic        bridge_sel, ctrl_sel, ident_sel, rd_en, wr_en;
    logic [6:0]  addr;
    logic [31:0] wdata, rdata;
    logic        core_rst, core_rd, core_wr, core_irq, host_irq;
    logic [4:0]  core_addr;
    logic [7:0]  core_wdata, core_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    // core model: each register returns 0xC0 | offset
    assign core_rdata = {3'b110, core_addr};

    can_host_glue u0 (
        .clk(clk), .rst(rst), .bridge_sel(bridge_sel), .ctrl_sel(ctrl_sel),
        .ident_sel(ident_sel), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .core_rst(core_rst), .core_rd(core_rd),
        .core_wr(core_wr), .core_addr(core_addr), .core_wdata(core_wdata),
        .core_rdata(core_rdata), .core_irq(core_irq), .host_irq(host_irq)
    );

    typedef struct packed {
        logic [1:0]  win;     // 0 none, 1 bridge, 2 controller, 3 ident
        logic        rd;
        logic        wr;
        logic [6:0]  a;
        logic [31:0] wd;
        logic        irq;
        logic [31:0] exp_rd;
        logic        exp_hi;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VEC [NV] = '{
        '{2'd1,1'b1,1'b0,7'h38,32'h0,        1'b0,32'h0,        1'b0,4'd9}, // R9 cleared word
        '{2'd1,1'b0,1'b1,7'h38,32'hA5A57F3C, 1'b0,32'h0,        1'b0,4'd2}, // R2 write, enable set
        '{2'd1,1'b1,1'b0,7'h38,32'h0,        1'b0,32'hA5257F3C, 1'b0,4'd3}, // R3 bit23 live low
        '{2'd0,1'b0,1'b0,7'h00,32'h0,        1'b1,32'h0,        1'b1,4'd4}, // R4 edge passes
        '{2'd1,1'b1,1'b0,7'h38,32'h0,        1'b1,32'hA5A57F3C, 1'b1,4'd3}, // R3 bit23 live high
        '{2'd1,1'b0,1'b1,7'h38,32'h0,        1'b1,32'h0,        1'b0,4'd4}, // R4 disable while pending
        '{2'd0,1'b0,1'b0,7'h00,32'h0,        1'b0,32'h0,        1'b0,4'd4}, // R4 held off
        '{2'd0,1'b0,1'b0,7'h00,32'h0,        1'b1,32'h0,        1'b0,4'd4}, // R4 rise blocked
        '{2'd1,1'b0,1'b1,7'h38,32'h00002000, 1'b1,32'h0,        1'b1,4'd4}, // R4 enable while pending
        '{2'd1,1'b0,1'b1,7'h10,32'hFFFFFFFF, 1'b1,32'h0,        1'b1,4'd1}, // R1 stray write
        '{2'd1,1'b1,1'b0,7'h10,32'h0,        1'b1,32'h0,        1'b1,4'd1}, // R1 stray read
        '{2'd1,1'b1,1'b0,7'h38,32'h0,        1'b1,32'h00802000, 1'b1,4'd1}, // R1 word untouched
        '{2'd0,1'b0,1'b0,7'h00,32'h0,        1'b0,32'h0,        1'b0,4'd4}, // R4 fall passes
        '{2'd2,1'b0,1'b1,7'h05,32'h0000005A, 1'b0,32'h0,        1'b0,4'd6}, // R6 write
        '{2'd2,1'b1,1'b0,7'h05,32'h0,        1'b0,32'h000000C5, 1'b0,4'd6}, // R6 read
        '{2'd2,1'b1,1'b0,7'h1F,32'h0,        1'b0,32'h000000DF, 1'b0,4'd6}, // R6 top offset
        '{2'd2,1'b0,1'b1,7'h20,32'h000000AA, 1'b0,32'h0,        1'b0,4'd7}, // R7 write blocked
        '{2'd2,1'b1,1'b0,7'h20,32'h0,        1'b0,32'h0,        1'b0,4'd7}, // R7 read at 0x20
        '{2'd2,1'b1,1'b0,7'h7F,32'h0,        1'b0,32'h0,        1'b0,4'd7}, // R7 read at 0x7F
        '{2'd3,1'b1,1'b0,7'h07,32'h0,        1'b0,32'h000000D0, 1'b0,4'd8}, // R8 version
        '{2'd3,1'b1,1'b0,7'h00,32'h0,        1'b0,32'h0,        1'b0,4'd8}, // R8 other offset
        '{2'd3,1'b0,1'b1,7'h07,32'h000000FF, 1'b0,32'h0,        1'b0,4'd8}, // R8 write ignored
        '{2'd3,1'b1,1'b0,7'h07,32'h0,        1'b0,32'h000000D0, 1'b0,4'd8}  // R8 unchanged
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic idle();
        bridge_sel = 0; ctrl_sel = 0; ident_sel = 0;
        rd_en = 0; wr_en = 0; addr = '0; wdata = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle();
        core_irq = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        chk(core_rst == 1'b1, "R9 core_rst during reset", 32'(core_rst), 32'd1);
        chk(host_irq == 1'b0, "R9 host_irq during reset", 32'(host_irq), 32'd0);
        chk(rdata == 32'h0, "R5 rdata during reset", rdata, 32'h0);
        rst = 0;
        @(negedge clk);
        chk(core_rst == 1'b0, "R9 core_rst released", 32'(core_rst), 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic exp_crd, exp_cwr;
            bridge_sel = (VEC[i].win == 2'd1);
            ctrl_sel   = (VEC[i].win == 2'd2);
            ident_sel  = (VEC[i].win == 2'd3);
            rd_en = VEC[i].rd; wr_en = VEC[i].wr;
            addr  = VEC[i].a;  wdata = VEC[i].wd;
            core_irq = VEC[i].irq;
            exp_crd = ctrl_sel && VEC[i].rd && (VEC[i].a < 7'h20);
            exp_cwr = ctrl_sel && VEC[i].wr && (VEC[i].a < 7'h20);
            #1;
            chk(core_rd == exp_crd, $sformatf("R%0d core_rd vec %0d", VEC[i].req, i),
                32'(core_rd), 32'(exp_crd));
            chk(core_wr == exp_cwr, $sformatf("R%0d core_wr vec %0d", VEC[i].req, i),
                32'(core_wr), 32'(exp_cwr));
            if (exp_cwr || exp_crd)
                chk(core_addr == VEC[i].a[4:0] && core_wdata == VEC[i].wd[7:0],
                    $sformatf("R6 core addr/data vec %0d", i),
                    {19'd0, core_addr, core_wdata}, {19'd0, VEC[i].a[4:0], VEC[i].wd[7:0]});
            @(negedge clk);
            chk(rdata == VEC[i].exp_rd, $sformatf("R%0d rdata vec %0d", VEC[i].req, i),
                rdata, VEC[i].exp_rd);
            chk(host_irq == VEC[i].exp_hi, $sformatf("R%0d host_irq vec %0d", VEC[i].req, i),
                32'(host_irq), 32'(VEC[i].exp_hi));
        end

        // R5: no read in previous cycle gives zero data
        idle();
        @(negedge clk);
        chk(rdata == 32'h0, "R5 idle rdata", rdata, 32'h0);

        // R9: reset while enabled and pending
        bridge_sel = 1; wr_en = 1; addr = 7'h38; wdata = 32'h00002000; core_irq = 1;
        @(negedge clk);
        idle();
        chk(host_irq == 1'b1, "R4 pending and enabled", 32'(host_irq), 32'd1);
        rst = 1;
        @(negedge clk);
        chk(core_rst == 1'b1, "R9 core_rst pulse", 32'(core_rst), 32'd1);
        chk(host_irq == 1'b0, "R9 host_irq cleared", 32'(host_irq), 32'd0);
        rst = 0;
        @(negedge clk);
        chk(core_rst == 1'b0, "R9 core_rst ends", 32'(core_rst), 32'd0);
        chk(host_irq == 1'b0, "R9 disabled after reset", 32'(host_irq), 32'd0);
        bridge_sel = 1; rd_en = 1; addr = 7'h38;
        @(negedge clk);
        idle();
        chk(rdata == 32'h00800000, "R9 word cleared with live status", rdata, 32'h00800000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule